// File: doc/BRIEF.md
# One-Hot Timed Register Transfer Unit

This block moves one of several source words into a single destination register. Each source register holds a data word. Software or a test harness writes it through its own write strobe and data lane. A set of timing strobes decides which source is copied into the destination at a clock edge. At most one strobe is expected to be high in a cycle. The block turns the one-hot strobes into a binary multiplexer select and a destination load enable, so the sequencer that produces the strobes never has to encode them.

When no strobe is high, the destination keeps its word. When more than one strobe is high, the block reports the violation on a flag and refuses the transfer, so a broken sequencer cannot corrupt the destination with a merged select. A source that is written and copied in the same cycle gives the destination its value from before that edge, which is plain register semantics.

Top module: `timed_bus_xfer`

## Requirements
- R1: While rst_ni is low, and at the first edge after it is released, every source word, the destination word, `load_o` and `conflict_o` are zero.
- R2: At a rising edge where `src_we_i[i]` is high, source i takes lane i of `src_wdata_i` (bits i*8+7 down to i*8). Sources whose strobe is low keep their words.
- R3: When only `slot_i[k]` is high, the next rising edge loads the destination with the word that source k held before that edge.
- R4: `sel_o` is combinational from `slot_i` for every pattern. Bit 0 is `slot_i[1] | slot_i[3]` and bit 1 is `slot_i[2] | slot_i[3]`, so a single strobe k gives sel_o = k.
- R5: `load_o` is high exactly when one, and only one, bit of `slot_i` is high.
- R6: When `slot_i` is all zero, the destination keeps its word across the edge.
- R7: When two or more bits of `slot_i` are high, `conflict_o` is high, `load_o` is low and the destination keeps its word.
- R8: If source k is written in the same cycle that strobe k alone is high, the destination receives the old word of source k. The source itself takes the new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_we_i | input | 4 | Per-source write strobe |
| src_wdata_i | input | 32 | Packed write data, lane i feeds source i |
| slot_i | input | 4 | One-hot timing strobes, bit k selects source k |
| src_q_o | output | 32 | Packed source register contents, lane i is source i |
| dst_q_o | output | 8 | Destination register contents |
| sel_o | output | 2 | Encoded multiplexer select |
| load_o | output | 1 | Destination load enable |
| conflict_o | output | 1 | More than one timing strobe is high |

## Verification
The bench drives all sixteen strobe patterns, each after loading the sources with distinct words that differ for every pattern. The single-bit patterns show whether the select encoding sends each source to the right place. The all-zero pattern separates a hold from a spurious load. The eleven multi-bit patterns show whether the conflict detection is complete and whether a merged select leaks into the destination. A separate run writes a source and selects it in the same cycle, and another writes only some of the lanes. Together these separate old-value from new-value capture and show whether the per-lane write enables are independent.

// File: rtl/timed_bus_xfer_pkg.sv
package timed_bus_xfer_pkg;
  localparam int unsigned DATA_W_DEF = 8;
  localparam int unsigned N_SRC_DEF  = 4;
endpackage

// File: rtl/xfer_src_regs.sv
module xfer_src_regs #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned N_SRC  = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [N_SRC-1:0]          we_i,
  input  logic [N_SRC*DATA_W-1:0]   wdata_i,
  output logic [N_SRC*DATA_W-1:0]   q_o
);
  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    q <= '0;
      else if (we_i[i]) q <= wdata_i[i*DATA_W +: DATA_W];
    end
    assign q_o[i*DATA_W +: DATA_W] = q;
  end
endmodule

// File: rtl/xfer_slot_enc.sv
module xfer_slot_enc #(
  parameter int unsigned N_SRC = 4,
  localparam int unsigned SEL_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0] slot_i,
  output logic [SEL_W-1:0] sel_o,
  output logic             load_o,
  output logic             conflict_o
);
  logic seen, multi;

  // OR of hot indices: bit b collects every strobe whose index has bit b set
  always_comb begin
    sel_o = '0;
    seen  = 1'b0;
    multi = 1'b0;
    for (int k = 0; k < N_SRC; k++) begin
      if (slot_i[k]) begin
        sel_o = sel_o | SEL_W'(k);
        if (seen) multi = 1'b1;
        seen = 1'b1;
      end
    end
  end

  assign conflict_o = multi;
  assign load_o     = seen & ~multi;
endmodule

// File: rtl/xfer_dst_reg.sv
module xfer_dst_reg #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned N_SRC  = 4,
  localparam int unsigned SEL_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [N_SRC*DATA_W-1:0] src_i,
  input  logic [SEL_W-1:0]        sel_i,
  input  logic                    load_i,
  output logic [DATA_W-1:0]       q_o
);
  logic [DATA_W-1:0] src_arr [N_SRC];
  logic [DATA_W-1:0] mux_out;

  for (genvar i = 0; i < N_SRC; i++) begin : g_unpack
    assign src_arr[i] = src_i[i*DATA_W +: DATA_W];
  end

  always_comb begin
    mux_out = '0;
    for (int k = 0; k < N_SRC; k++) begin
      if (sel_i == SEL_W'(k)) mux_out = src_arr[k];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (load_i) q_o <= mux_out;
  end
endmodule

// File: rtl/timed_bus_xfer.sv
module timed_bus_xfer
  import timed_bus_xfer_pkg::*;
#(
  parameter int unsigned DATA_W = DATA_W_DEF,
  parameter int unsigned N_SRC  = N_SRC_DEF,
  localparam int unsigned SEL_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [N_SRC-1:0]        src_we_i,
  input  logic [N_SRC*DATA_W-1:0] src_wdata_i,
  input  logic [N_SRC-1:0]        slot_i,
  output logic [N_SRC*DATA_W-1:0] src_q_o,
  output logic [DATA_W-1:0]       dst_q_o,
  output logic [SEL_W-1:0]        sel_o,
  output logic                    load_o,
  output logic                    conflict_o
);
  xfer_src_regs #(.DATA_W(DATA_W), .N_SRC(N_SRC)) u_src (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (src_we_i),
    .wdata_i (src_wdata_i),
    .q_o     (src_q_o)
  );

  xfer_slot_enc #(.N_SRC(N_SRC)) u_enc (
    .slot_i     (slot_i),
    .sel_o      (sel_o),
    .load_o     (load_o),
    .conflict_o (conflict_o)
  );

  xfer_dst_reg #(.DATA_W(DATA_W), .N_SRC(N_SRC)) u_dst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .src_i  (src_q_o),
    .sel_i  (sel_o),
    .load_i (load_o),
    .q_o    (dst_q_o)
  );
endmodule

// File: rtl/timed_bus_xfer_chk.sv
module timed_bus_xfer_chk #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned N_SRC  = 4,
  localparam int unsigned SEL_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic [N_SRC-1:0]        src_we_i,
  input logic [N_SRC*DATA_W-1:0] src_wdata_i,
  input logic [N_SRC-1:0]        slot_i,
  input logic [N_SRC*DATA_W-1:0] src_q_o,
  input logic [DATA_W-1:0]       dst_q_o,
  input logic [SEL_W-1:0]        sel_o,
  input logic                    load_o,
  input logic                    conflict_o
);
  logic [DATA_W-1:0] src_arr [N_SRC];
  logic [DATA_W-1:0] sel_word;

  for (genvar i = 0; i < N_SRC; i++) begin : g_arr
    assign src_arr[i] = src_q_o[i*DATA_W +: DATA_W];

    // R2
    src_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      src_we_i[i] |=> src_q_o[i*DATA_W +: DATA_W] == $past(src_wdata_i[i*DATA_W +: DATA_W]));
    // R2
    src_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !src_we_i[i] |=> $stable(src_q_o[i*DATA_W +: DATA_W]));
  end

  assign sel_word = src_arr[sel_o];

  // R5
  load_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o == ($countones(slot_i) == 1));
  // R7
  conflict_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conflict_o == ($countones(slot_i) > 1));
  // R4
  sel_points_hot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |-> slot_i[sel_o]);
  // R3
  dst_transfer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> dst_q_o == $past(sel_word));
  // R6
  dst_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_o |=> $stable(dst_q_o));
  // R7
  conflict_no_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conflict_o |-> !load_o);
endmodule

bind timed_bus_xfer timed_bus_xfer_chk #(.DATA_W(DATA_W), .N_SRC(N_SRC)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .src_we_i    (src_we_i),
  .src_wdata_i (src_wdata_i),
  .slot_i      (slot_i),
  .src_q_o     (src_q_o),
  .dst_q_o     (dst_q_o),
  .sel_o       (sel_o),
  .load_o      (load_o),
  .conflict_o  (conflict_o)
);

// File: tb/timed_bus_xfer_tb_top.sv
module timed_bus_xfer_tb_top;
  localparam int DW = 8;
  localparam int NS = 4;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [NS-1:0] src_we_i = '0;
  logic [NS*DW-1:0] src_wdata_i = '0;
  logic [NS-1:0] slot_i = '0;
  logic [NS*DW-1:0] src_q_o;
  logic [DW-1:0] dst_q_o;
  logic [1:0]    sel_o;
  logic          load_o;
  logic          conflict_o;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] m_src [NS];
  logic [DW-1:0] m_dst;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  timed_bus_xfer dut_i (
    .clk_i, .rst_ni, .src_we_i, .src_wdata_i, .slot_i,
    .src_q_o, .dst_q_o, .sel_o, .load_o, .conflict_o
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int p, input int i);
    return DW'((p * 37 + i * 71 + 5) & 8'hFF);
  endfunction

  task automatic check_srcs(input string req);
    for (int i = 0; i < NS; i++)
      chk(req, $sformatf("src%0d", i), 32'(src_q_o[i*DW +: DW]), 32'(m_src[i]));
  endtask

  initial begin
    for (int i = 0; i < NS; i++) m_src[i] = '0;
    m_dst = '0;
    #22;
    // R1 reset state
    check_srcs("R1");
    chk("R1", "dst", 32'(dst_q_o), 0);
    chk("R1", "load", 32'(load_o), 0);
    chk("R1", "conflict", 32'(conflict_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(posedge clk_i); #1;
    chk("R1", "dst after release", 32'(dst_q_o), 0);
    check_srcs("R1");

    // Sweep over all strobe patterns: R3 R4 R5 R6 R7
    for (int p = 0; p < 16; p++) begin
      @(negedge clk_i);
      src_we_i = '1;
      for (int i = 0; i < NS; i++) src_wdata_i[i*DW +: DW] = pat(p, i);
      @(posedge clk_i); #1;
      for (int i = 0; i < NS; i++) m_src[i] = pat(p, i);
      check_srcs("R2");
      @(negedge clk_i);
      src_we_i = '0;
      slot_i = 4'(p);
      #1;
      begin
        logic [1:0] s_exp;
        int ones;
        s_exp = {slot_i[2] | slot_i[3], slot_i[1] | slot_i[3]};
        ones = $countones(slot_i);
        chk("R4", $sformatf("sel p=%0d", p), 32'(sel_o), 32'(s_exp));
        chk("R5", $sformatf("load p=%0d", p), 32'(load_o), 32'(ones == 1));
        chk("R7", $sformatf("conflict p=%0d", p), 32'(conflict_o), 32'(ones > 1));
        if (ones == 1) m_dst = m_src[s_exp];
        @(posedge clk_i); #1;
        if (ones == 1)      chk("R3", $sformatf("dst p=%0d", p), 32'(dst_q_o), 32'(m_dst));
        else if (ones == 0) chk("R6", "dst hold", 32'(dst_q_o), 32'(m_dst));
        else                chk("R7", $sformatf("dst hold p=%0d", p), 32'(dst_q_o), 32'(m_dst));
      end
      @(negedge clk_i);
      slot_i = '0;
    end

    // R8 same-cycle write and transfer, each source
    for (int k = 0; k < NS; k++) begin
      @(negedge clk_i);
      src_we_i = 4'(1 << k);
      src_wdata_i[k*DW +: DW] = ~m_src[k];
      slot_i = 4'(1 << k);
      m_dst = m_src[k];
      @(posedge clk_i); #1;
      m_src[k] = ~m_dst;
      chk("R8", $sformatf("dst old word k=%0d", k), 32'(dst_q_o), 32'(m_dst));
      chk("R8", $sformatf("src new word k=%0d", k), 32'(src_q_o[k*DW +: DW]), 32'(m_src[k]));
    end

    // R2 partial write leaves other lanes untouched
    @(negedge clk_i);
    slot_i = '0;
    src_we_i = 4'b0101;
    src_wdata_i = 32'hA1B2C3D4;
    @(posedge clk_i); #1;
    m_src[0] = 8'hD4;
    m_src[2] = 8'hB2;
    check_srcs("R2");
    chk("R6", "dst hold after writes", 32'(dst_q_o), 32'(m_dst));

    @(negedge clk_i);
    src_we_i = '0;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("Watchdog expired before the sequence completed");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule